// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block owns the refresh duty of an asynchronous DRAM array. After reset it waits out a long power-up pause. It then runs a fixed burst of refresh cycles that rely on the memory's own row counter, with the column strobe dropped ahead of the row strobe. Only after that does it raise `init_done`. Until then the access sequencer must keep away from the memory pins.

In normal operation an internal timer marks each refresh interval, counted in clock cycles. Every mark adds one owed refresh to a small saturating count. While any refresh is owed, the block asks for the memory bus with `ref_req`. The access sequencer answers with `ref_gnt` and must hold it for as long as `ref_req` stays high. Under one grant the block works off every owed refresh back to back, with a row precharge between cycles. It drops `ref_req` once nothing is owed and the last precharge has ended. All ranks are strobed together. The write enable pin stays high throughout, so no refresh cycle can be taken as a write.

The request/grant pair is a plain two-wire handshake, not a data stream. `ref_req` is the only back-pressure the block applies, and `ref_gnt` is the only back-pressure it accepts. There is no data path. All timing is given as whole clock-cycle counts set by parameters.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: Reset state: the row and column strobes of all ranks and the write enable are high, and `init_done` and `ref_req` are low. Once reset is released, the column strobe first falls on the PAUSE_CYC+1-th rising clock edge after release.
- R2: Before `init_done` rises, exactly INIT_CYCLES refresh cycles (falling edges of the row strobe) take place without any grant, and `ref_req` stays low. `init_done` then stays high until reset.
- R3: In every refresh cycle, the column strobe is low for exactly CSR_CYC cycles before the row strobe falls. It then stays low for exactly CHR_CYC cycles with the row strobe low.
- R4: The row strobe stays low for exactly RAS_CYC cycles per refresh. It is high for at least RP_CYC cycles before the column strobe falls again. Every rank carries the same strobe values.
- R5: The write enable output is high in every cycle.
- R6: After `init_done` rises, one refresh becomes owed every REFI_CYC cycles. With no grant given, `ref_req` goes high exactly REFI_CYC cycles after `init_done` goes high.
- R7: When `ref_gnt` is first sampled high while `ref_req` is high and the block is idle, the column strobe pins go low two rising edges later.
- R8: The count of owed refreshes saturates at OWED_MAX. After a long denial, one grant yields OWED_MAX cycles, plus at most one more if the interval timer expires during the burst.
- R9: Under one grant, all owed cycles run back to back. `ref_req` falls only once, after the last precharge, while all strobes are high.
- R10: After initialization, no refresh cycle starts while `ref_gnt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Bus grant from the access sequencer |
| ref_req | output | 1 | Bus request; high while refreshes are owed or a refresh is in progress |
| init_done | output | 1 | High once the power-up pause and the initialization cycles are complete |
| ras_n | output | RANKS | Row strobe, one per rank, active low |
| cas_n | output | RANKS | Column strobe, one per rank, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The checks take two things for granted about the access sequencer: `ref_gnt` stays high for as long as `ref_req` does, and reset is held for at least one clock edge. The bench's granter raises the grant only after it has seen `ref_req` high. It lowers the grant on the first sample where `ref_req` is low, so a grant is never withdrawn in the middle of a burst. Long phases with the grant held low create the saturation case and the request-without-grant case. Parameters are kept with RAS_CYC greater than CHR_CYC and every duration at least one cycle.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [2:0] {
    PH_PAUSE,
    PH_LEAD,
    PH_OVERLAP,
    PH_ROWHOLD,
    PH_PRECH,
    PH_IDLE
  } dref_phase_e;
endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
  parameter int unsigned PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick_o
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign tick_o = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick_o)   cnt <= '0;
    else               cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/dref_owed_ctr.sv
module dref_owed_ctr #(
  parameter int unsigned OWED_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic owed_nz_o
);
  localparam int W = $clog2(OWED_MAX + 1);
  localparam logic [W-1:0] TOP = W'(OWED_MAX);

  logic [W-1:0] owed;

  assign owed_nz_o = (owed != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else if (inc && !dec && owed != TOP) owed <= owed + W'(1);
    else if (dec && !inc && owed != '0)  owed <= owed - W'(1);
  end
endmodule

// File: rtl/dref_cycle_seq.sv
module dref_cycle_seq
  import dref_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 20000,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned CSR_CYC     = 1,
  parameter int unsigned CHR_CYC     = 1,
  parameter int unsigned RAS_CYC     = 6,
  parameter int unsigned RP_CYC      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic owed_nz,
  input  logic gnt,
  output logic ready_o,
  output logic step_done_o,
  output logic busy_o,
  output logic row_lo_o,
  output logic col_lo_o
);
  localparam int unsigned SPAN = PAUSE_CYC + CSR_CYC + RAS_CYC + RP_CYC + 1;
  localparam int CW = $clog2(SPAN + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  dref_phase_e   phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len;
  logic [IW-1:0] init_left;
  logic          ready_q;
  logic          last;

  always_comb begin
    case (phase)
      PH_PAUSE:   len = CW'(PAUSE_CYC);
      PH_LEAD:    len = CW'(CSR_CYC);
      PH_OVERLAP: len = CW'(CHR_CYC);
      PH_ROWHOLD: len = CW'(RAS_CYC - CHR_CYC);
      PH_PRECH:   len = CW'(RP_CYC);
      default:    len = CW'(1);
    endcase
  end

  assign last = (cnt == len - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_PAUSE;
      cnt       <= '0;
      init_left <= IW'(INIT_CYCLES);
      ready_q   <= 1'b0;
    end else if (phase == PH_IDLE) begin
      cnt <= '0;
      if (owed_nz && gnt) phase <= PH_LEAD;
    end else if (!last) begin
      cnt <= cnt + CW'(1);
    end else begin
      cnt <= '0;
      case (phase)
        PH_PAUSE:   phase <= PH_LEAD;
        PH_LEAD:    phase <= PH_OVERLAP;
        PH_OVERLAP: phase <= PH_ROWHOLD;
        PH_ROWHOLD: begin
          phase <= PH_PRECH;
          if (!ready_q) init_left <= init_left - IW'(1);
        end
        PH_PRECH: begin
          if (!ready_q) begin
            if (init_left == '0) begin
              phase   <= PH_IDLE;
              ready_q <= 1'b1;
            end else begin
              phase <= PH_LEAD;
            end
          end else if (owed_nz && gnt) begin
            phase <= PH_LEAD;
          end else begin
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign ready_o     = ready_q;
  assign step_done_o = (phase == PH_ROWHOLD) && last && ready_q;
  assign busy_o      = (phase == PH_LEAD) || (phase == PH_OVERLAP) ||
                       (phase == PH_ROWHOLD) || (phase == PH_PRECH);
  assign row_lo_o    = (phase == PH_OVERLAP) || (phase == PH_ROWHOLD);
  assign col_lo_o    = (phase == PH_LEAD) || (phase == PH_OVERLAP);
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int unsigned RANKS       = 2,
  parameter int unsigned PAUSE_CYC   = 20000,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned REFI_CYC    = 1560,
  parameter int unsigned OWED_MAX    = 8,
  parameter int unsigned CSR_CYC     = 1,
  parameter int unsigned CHR_CYC     = 1,
  parameter int unsigned RAS_CYC     = 6,
  parameter int unsigned RP_CYC      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             init_done,
  output logic [RANKS-1:0] ras_n,
  output logic [RANKS-1:0] cas_n,
  output logic             we_n
);
  logic ready;
  logic tick;
  logic step_done;
  logic owed_nz;
  logic busy;
  logic row_lo;
  logic col_lo;

  dref_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ready),
    .tick_o (tick)
  );

  dref_owed_ctr #(.OWED_MAX(OWED_MAX)) u_owed (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (tick),
    .dec       (step_done),
    .owed_nz_o (owed_nz)
  );

  dref_cycle_seq #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INIT_CYCLES (INIT_CYCLES),
    .CSR_CYC     (CSR_CYC),
    .CHR_CYC     (CHR_CYC),
    .RAS_CYC     (RAS_CYC),
    .RP_CYC      (RP_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .owed_nz     (owed_nz),
    .gnt         (ref_gnt),
    .ready_o     (ready),
    .step_done_o (step_done),
    .busy_o      (busy),
    .row_lo_o    (row_lo),
    .col_lo_o    (col_lo)
  );

  assign ref_req   = ready && (owed_nz || busy);
  assign init_done = ready;
  assign we_n      = 1'b1;

  for (genvar g = 0; g < RANKS; g++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ras_n[g] <= 1'b1;
        cas_n[g] <= 1'b1;
      end else begin
        ras_n[g] <= !row_lo;
        cas_n[g] <= !col_lo;
      end
    end
  end
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int unsigned RANKS   = 2,
  parameter int unsigned RAS_CYC = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic             init_done,
  input logic [RANKS-1:0] ras_n,
  input logic [RANKS-1:0] cas_n,
  input logic             we_n
);
  logic [15:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || ras_n[0]) lo_cnt <= '0;
    else                    lo_cnt <= lo_cnt + 16'd1;
  end

  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> (!cas_n[0] && $past(!cas_n[0])));

  a_r4_cas_high_at_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |-> cas_n[0]);

  a_r4_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |-> (lo_cnt == 16'(RAS_CYC)));

  a_r4_ranks_match: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == {RANKS{ras_n[0]}}) && (cas_n == {RANKS{cas_n[0]}}));

  a_r2_no_req_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req);

  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r10_cas_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n[0]) && init_done) |-> $past(ref_gnt));

  a_r9_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_req) |-> (ras_n[0] && cas_n[0] && we_n));
endmodule

bind dram_refresh_ctrl dram_refresh_chk #(.RANKS(RANKS), .RAS_CYC(RAS_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_gnt   (ref_gnt),
  .ref_req   (ref_req),
  .init_done (init_done),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n)
);

// File: tb/test_dram_refresh_ctrl.sv
module test_dram_refresh_ctrl;
  localparam int RANKS = 2, PAUSE = 20, INITN = 8, REFI = 50, OMAX = 4;
  localparam int CSR = 1, CHR = 2, RASW = 4, RP = 3;

  logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0;
  logic ref_req, init_done, we_n;
  logic [RANKS-1:0] ras_n, cas_n;

  always #5 clk = ~clk;

  dram_refresh_ctrl #(
    .RANKS(RANKS), .PAUSE_CYC(PAUSE), .INIT_CYCLES(INITN), .REFI_CYC(REFI),
    .OWED_MAX(OMAX), .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASW), .RP_CYC(RP)
  ) i_dram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int mode = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: phases 0 pause,1 lead,2 overlap,3 row hold,4 precharge,5 idle
  int m_ph = 0, m_cnt = 0, m_left = INITN, m_owed = 0, m_t = 0;
  bit m_done = 0, e_ras_n = 1, e_cas_n = 1;

  function automatic int plen(input int ph);
    case (ph)
      0: return PAUSE;
      1: return CSR;
      2: return CHR;
      3: return RASW - CHR;
      4: return RP;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    int nph, ncnt, nleft, dec;
    bit tick, nd, last;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_left = INITN; m_owed = 0; m_t = 0;
      m_done = 0; e_ras_n = 1; e_cas_n = 1;
    end else begin
      e_ras_n = !(m_ph == 2 || m_ph == 3);
      e_cas_n = !(m_ph == 1 || m_ph == 2);
      tick  = m_done && (m_t == REFI - 1);
      last  = (m_cnt == plen(m_ph) - 1);
      nph = m_ph; ncnt = m_cnt + 1; nleft = m_left; dec = 0; nd = m_done;
      if (m_ph == 5) begin
        ncnt = 0;
        if (m_owed > 0 && ref_gnt) nph = 1;
      end else if (last) begin
        ncnt = 0;
        case (m_ph)
          0: nph = 1;
          1: nph = 2;
          2: nph = 3;
          3: begin nph = 4; if (!m_done) nleft = m_left - 1; else dec = 1; end
          default: begin
            if (!m_done) begin
              if (m_left == 0) begin nph = 5; nd = 1; end else nph = 1;
            end else nph = (m_owed > 0 && ref_gnt) ? 1 : 5;
          end
        endcase
      end
      m_t = !m_done ? 0 : (tick ? 0 : m_t + 1);
      m_owed = m_owed + int'(tick) - dec;
      if (m_owed > OMAX) m_owed = OMAX;
      m_ph = nph; m_cnt = ncnt; m_left = nleft; m_done = nd;
    end
  end

  // monitors
  int since_rel = 0, first_cas_at = -1, done_at = -1, req_at = -1;
  int ras_falls = 0, init_falls = 0, req_falls = 0;
  int cas_lo_run = 0, ras_lo_run = 0, ras_hi_run = 0;
  bit p_r = 1, p_c = 1, p_q = 0, p_d = 0;

  always @(negedge clk) begin
    bit r, c, e_req;
    if (rst_n) begin
      since_rel++;
      e_req = m_done && (m_owed > 0 || (m_ph >= 1 && m_ph <= 4));
      chk(ras_n == {RANKS{e_ras_n}}, "R4 ras_n vs model", int'(ras_n), int'({RANKS{e_ras_n}}));
      chk(cas_n == {RANKS{e_cas_n}}, "R3 cas_n vs model", int'(cas_n), int'({RANKS{e_cas_n}}));
      chk(we_n == 1'b1, "R5 we_n high", int'(we_n), 1);
      chk(ref_req == e_req, "R7 ref_req vs model", int'(ref_req), int'(e_req));
      chk(init_done == m_done, "R2 init_done vs model", int'(init_done), int'(m_done));
      r = ras_n[0]; c = cas_n[0];
      if (p_r && !r) begin
        chk(cas_lo_run == CSR, "R3 cas lead before ras", cas_lo_run, CSR);
        ras_falls++;
        if (!init_done) init_falls++;
      end
      if (!p_c && c && !r) chk(ras_lo_run == CHR, "R3 cas hold after ras", ras_lo_run, CHR);
      if (!p_r && r) chk(ras_lo_run == RASW, "R4 ras low width", ras_lo_run, RASW);
      if (p_c && !c) begin
        chk(ras_hi_run >= RP, "R4 precharge before cas", ras_hi_run, RP);
        if (first_cas_at < 0) first_cas_at = since_rel;
      end
      if (p_q && !ref_req) req_falls++;
      if (!p_d && init_done) done_at = since_rel;
      if (init_done && ref_req && req_at < 0) req_at = since_rel;
      cas_lo_run = c ? 0 : cas_lo_run + 1;
      ras_lo_run = r ? 0 : ras_lo_run + 1;
      ras_hi_run = r ? ras_hi_run + 1 : 0;
      p_r = r; p_c = c; p_q = ref_req; p_d = init_done;
      ref_gnt = (mode == 1) ? ref_req : 1'b0;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    int base, rf, s, n;
    repeat (5) step();
    chk(ras_n == '1 && cas_n == '1 && we_n, "R1 reset strobes high", int'(ras_n & cas_n), 3);
    chk(!init_done && !ref_req, "R1 reset init_done and req low", int'({init_done, ref_req}), 0);
    rst_n = 1'b1;
    while (!init_done) step();
    chk(first_cas_at == PAUSE + 1, "R1 pause length", first_cas_at, PAUSE + 1);
    chk(init_falls == INITN, "R2 init cycle count", init_falls, INITN);
    while (!ref_req) step();
    chk(req_at - done_at == REFI, "R6 first request interval", req_at - done_at, REFI);
    base = ras_falls;
    repeat (300) step();
    chk(ras_falls == base, "R10 no cycle without grant", ras_falls - base, 0);
    mode = 1; base = ras_falls; rf = req_falls;
    step();
    while (ref_req) step();
    n = ras_falls - base;
    chk(n >= OMAX && n <= OMAX + 1, "R8 saturated burst size", n, OMAX);
    chk(req_falls - rf == 1, "R9 single release per grant", req_falls - rf, 1);
    mode = 0;
    while (!ref_req) step();
    s = since_rel;
    mode = 1;
    while (cas_n[0]) step();
    chk(since_rel - s == 3, "R7 grant to cas latency", since_rel - s, 3);
    repeat (2000) step();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule